// File: doc/BRIEF.md
# Piecewise-Linear Gamma Compressor

This block maps a stream of 10-bit luminance samples onto 8-bit output codes through a programmable transfer curve. The curve covers luminance 0 to 896. It is built from ten straight segments that join at eleven fixed input knots: 0, 64, 128, 192, 256, 384, 512, 640, 768, 832 and 896. Software programs the output code at each knot. Inside a segment the block interpolates linearly between the two knot codes. Inputs above the last knot take the code of the last knot.

Samples arrive on a valid/ready input and leave on a valid/ready output after two cycles. Back-pressure stalls the whole pipe. The input is ready in any cycle where the output holds nothing or the output is being taken, so `in_ready` depends combinationally on `out_ready`. While `out_valid` is high and `out_ready` is low, the output code holds steady.

Knot writes go to a pending copy of the curve. A one-cycle `frame_start` pulse copies the pending curve into the active one. This means a frame never mixes two curves. A status pin reports whether the pending curve is non-monotonic.

Top module: `gamma_compress`

## Requirements
- R1: After reset, `out_valid` is low and `curve_bad` is low. Both the active and the pending knot codes are round(x_k × 255 / 896) for knot inputs x_k = 0, 64, 128, 192, 256, 384, 512, 640, 768, 832, 896, giving 0, 18, 36, 55, 73, 109, 146, 182, 219, 237, 255.
- R2: For an input x in segment k (x_k ≤ x < x_{k+1}, or x = 896 in segment 9), the output is y_k + floor(((x − x_k)·(y_{k+1} − y_k) + w/2) / w). Here w = x_{k+1} − x_k is 64 or 128, and y are the active knot codes.
- R3: An input above 896 produces the active code of knot 10.
- R4: A sample offered in cycle c with `in_ready` high appears on the output in cycle c+2 when `out_ready` has stayed high. Outputs leave in input order, one per accepted input.
- R5: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_code` stay unchanged into the next cycle.
- R6: A write with `cfg_we` high stores `cfg_val` into pending knot `cfg_idx` (0 to 10). It has no effect on outputs until a `frame_start` pulse.
- R7: On a cycle with `frame_start` high, the pending curve becomes active at the clock edge. A sample accepted in that same cycle still uses the old curve. A write in that same cycle lands only in the pending curve.
- R8: A write with `cfg_idx` 11 to 15 is ignored.
- R9: `curve_bad` is high exactly while some pending knot code is lower than the code of the knot before it. A non-monotonic curve is still applied as programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts the input sample this cycle |
| in_luma | input | 10 | Luminance sample |
| out_valid | output | 1 | Output code present |
| out_ready | input | 1 | Consumer takes the output code |
| out_code | output | 8 | Compressed output code |
| cfg_we | input | 1 | Knot write strobe |
| cfg_idx | input | 4 | Knot index, 0 to 10 valid |
| cfg_val | input | 8 | Knot output code to write |
| frame_start | input | 1 | One-cycle pulse that activates the pending curve |
| curve_bad | output | 1 | Pending curve is non-monotonic |

## Verification
The bench sweeps every input code from 0 to 1023 against the reset curve. This separates segment selection at each knot, the two segment widths and the clamp above 896. It then loads a steep, non-monotonic curve without a frame pulse, which shows whether writes leak into the stream early. After a pulse it sweeps again to exercise negative slopes and rounding on large rises. A pulse that coincides with an accepted sample and a write tests the switch-over edge. Finally a phase with out-of-range indices and a toggling `out_ready` checks ordering and holding under back-pressure.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int NSEG   = 10;
  localparam int NKNOT  = NSEG + 1;
  localparam int IN_MAX = 896;

  // fixed input position of each knot
  function automatic int knot_x(input int k);
    case (k)
      0: return 0;     1: return 64;    2: return 128;
      3: return 192;   4: return 256;   5: return 384;
      6: return 512;   7: return 640;   8: return 768;
      9: return 832;   default: return 896;
    endcase
  endfunction

  // log2 of segment width (widths are 64 or 128)
  function automatic int seg_shift(input int k);
    return (k >= 4 && k <= 7) ? 7 : 6;
  endfunction

  // reset code of a knot: rounded straight line to full scale
  function automatic int knot_default(input int k, input int code_max);
    return (knot_x(k) * code_max + IN_MAX / 2) / IN_MAX;
  endfunction
endpackage

// File: rtl/gamma_curve_regs.sv
module gamma_curve_regs
  import gamma_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [3:0]                    cfg_idx,
  input  logic [CODE_W-1:0]             cfg_val,
  input  logic                          frame_start,
  output logic [NKNOT-1:0][CODE_W-1:0]  act_tbl,
  output logic                          curve_bad
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic [NKNOT-1:0][CODE_W-1:0] pend_q, act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NKNOT; k++) begin
        pend_q[k] <= CODE_W'(knot_default(k, CODE_MAX));
        act_q[k]  <= CODE_W'(knot_default(k, CODE_MAX));
      end
    end else begin
      if (cfg_we && int'(cfg_idx) < NKNOT) pend_q[cfg_idx] <= cfg_val;
      if (frame_start) act_q <= pend_q;
    end
  end

  logic [NSEG-1:0] drop;
  generate
    for (genvar s = 0; s < NSEG; s++) begin : g_mono
      assign drop[s] = pend_q[s+1] < pend_q[s];
    end
  endgenerate

  assign curve_bad = |drop;
  assign act_tbl   = act_q;

  // R6
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_q));
endmodule

// File: rtl/gamma_interp.sv
module gamma_interp
  import gamma_pkg::*;
#(
  parameter int LUMA_W = 10,
  parameter int CODE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          adv,
  input  logic                          s0_vld,
  input  logic [LUMA_W-1:0]             s0_luma,
  input  logic [NKNOT-1:0][CODE_W-1:0]  tbl,
  output logic                          s2_vld,
  output logic [CODE_W-1:0]             s2_code
);
  localparam int DX_W = 8;
  localparam int RS_W = CODE_W + 1;
  localparam int PW   = DX_W + RS_W + 1;

  // stage 0 -> 1: segment lookup
  logic [3:0]             seg;
  logic [DX_W-1:0]        dx;
  logic [2:0]             sh;
  logic [CODE_W-1:0]      base;
  logic signed [RS_W-1:0] rise;

  always_comb begin
    seg = '0;
    dx  = DX_W'(s0_luma);
    sh  = 3'(seg_shift(0));
    for (int k = 1; k < NSEG; k++) begin
      if (int'(s0_luma) >= knot_x(k)) begin
        seg = 4'(k);
        dx  = DX_W'(int'(s0_luma) - knot_x(k));
        sh  = 3'(seg_shift(k));
      end
    end
    if (int'(s0_luma) > IN_MAX) begin
      base = tbl[NKNOT-1];
      rise = '0;
      dx   = '0;
    end else begin
      base = tbl[seg];
      rise = $signed({1'b0, tbl[seg + 4'd1]}) - $signed({1'b0, tbl[seg]});
    end
  end

  logic                   s1_vld;
  logic [DX_W-1:0]        s1_dx;
  logic [2:0]             s1_sh;
  logic [CODE_W-1:0]      s1_base;
  logic signed [RS_W-1:0] s1_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
    end else if (adv) begin
      s1_vld <= s0_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && s0_vld) begin
      s1_dx   <= dx;
      s1_sh   <= sh;
      s1_base <= base;
      s1_rise <= rise;
    end
  end

  // stage 1 -> 2: interpolate and round
  logic signed [PW-1:0] prod, acc, frac, res;

  always_comb begin
    prod = $signed({1'b0, s1_dx}) * s1_rise;
    acc  = prod + (PW'(1) <<< (s1_sh - 3'd1));
    frac = acc >>> s1_sh;
    res  = $signed({{(PW-CODE_W){1'b0}}, s1_base}) + frac;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld <= 1'b0;
    end else if (adv) begin
      s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && s1_vld) s2_code <= res[CODE_W-1:0];
  end

  // R4
  s0_to_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s0_vld) |=> s1_vld);

  // R4
  s1_to_s2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_vld) |=> s2_vld);
endmodule

// File: rtl/gamma_compress.sv
module gamma_compress
  import gamma_pkg::*;
#(
  parameter int LUMA_W = 10,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LUMA_W-1:0] in_luma,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [CODE_W-1:0] cfg_val,
  input  logic              frame_start,
  output logic              curve_bad
);
  logic [NKNOT-1:0][CODE_W-1:0] act_tbl;
  logic                         adv;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  gamma_curve_regs #(.CODE_W(CODE_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_val     (cfg_val),
    .frame_start (frame_start),
    .act_tbl     (act_tbl),
    .curve_bad   (curve_bad)
  );

  gamma_interp #(.LUMA_W(LUMA_W), .CODE_W(CODE_W)) u_interp (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .s0_vld  (in_valid),
    .s0_luma (in_luma),
    .tbl     (act_tbl),
    .s2_vld  (out_valid),
    .s2_code (out_code)
  );

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));
endmodule

// File: tb/sim_gamma_compress.sv
module sim_gamma_compress;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, out_ready = 1'b1;
  logic [9:0] in_luma = '0;
  logic       cfg_we = 1'b0, frame_start = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [7:0] cfg_val = '0;
  logic       in_ready, out_valid, curve_bad;
  logic [7:0] out_code;

  always #4 clk = ~clk;

  gamma_compress u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_luma(in_luma), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_val(cfg_val), .frame_start(frame_start), .curve_bad(curve_bad)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int pend[11], act[11];
  int exp_q[$], tag_q[$], when_q[$];
  bit strict = 1'b1;
  bit done = 1'b0;

  function automatic int kx(int k);
    int xs[11] = '{0, 64, 128, 192, 256, 384, 512, 640, 768, 832, 896};
    return xs[k];
  endfunction

  function automatic int model(int x);
    int k, w, num, q;
    if (x > 896) return act[10];            // R3
    k = 0;
    for (int j = 1; j < 10; j++) if (x >= kx(j)) k = j;
    w   = kx(k + 1) - kx(k);
    num = (x - kx(k)) * (act[k + 1] - act[k]) + w / 2;
    q   = num / w;
    if (num < 0 && q * w != num) q = q - 1;  // floor
    return act[k] + q;                       // R2
  endfunction

  function automatic bit pend_bad();
    for (int k = 1; k < 11; k++) if (pend[k] < pend[k - 1]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string req, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic step(bit v, int x, bit ordy, bit we, int idx, int val, bit sof);
    @(negedge clk);
    cyc++;
    check(curve_bad == pend_bad(), "R9 curve_bad", curve_bad, pend_bad());
    in_valid = v; in_luma = 10'(x); out_ready = ordy;
    cfg_we = we; cfg_idx = 4'(idx); cfg_val = 8'(val); frame_start = sof;
    #1;
    check(in_ready == (!out_valid || out_ready), "R5 in_ready", in_ready,
          !out_valid || out_ready);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 extra output", out_code, -1);
      end else begin
        int e = exp_q.pop_front();
        int t = tag_q.pop_front();
        int c = when_q.pop_front();
        check(int'(out_code) == e, (t > 896) ? "R3 clamp" : "R2 interp", out_code, e);
        if (strict) check(cyc - c == 2, "R4 latency", cyc - c, 2);
      end
    end
    if (v && in_ready) begin
      exp_q.push_back(model(x));   // uses curve active before this edge (R7)
      tag_q.push_back(x);
      when_q.push_back(cyc);
    end
    if (sof) act = pend;                       // R7
    if (we && idx <= 10) pend[idx] = val;      // R6, R8
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, 0);
    check(exp_q.size() == 0, "R4 all outputs delivered", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int lfsr = 32'h1d3;
    for (int k = 0; k < 11; k++) begin
      pend[k] = (kx(k) * 255 + 448) / 896;
      act[k]  = pend[k];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(curve_bad == 1'b0, "R1 curve_bad after reset", curve_bad, 0);
    check(act[3] == 55 && act[8] == 219, "R1 default table model", act[3], 55);

    // R1 R2 R3: full sweep on reset curve
    for (int x = 0; x < 1024; x++) step(1, x, 1, 0, 0, 0, 0);
    drain();

    // R6 R9: steep non-monotonic pending curve, no frame pulse yet
    begin
      int newc[11] = '{0, 200, 10, 255, 5, 250, 0, 128, 129, 255, 40};
      for (int k = 0; k < 11; k++) step(1, 37 * k + 100, 1, 1, k, newc[k], 0);
    end
    for (int x = 0; x < 1024; x += 13) step(1, x, 1, 0, 0, 0, 0);
    drain();

    // R7 frame pulse coinciding with accepted sample and a write
    step(1, 500, 1, 0, 0, 0, 0);
    step(1, 500, 1, 1, 4, 90, 1);
    step(1, 500, 1, 0, 0, 0, 0);
    for (int x = 0; x < 1024; x += 3) step(1, x, 1, 0, 0, 0, 0);
    drain();

    // R8: out-of-range indices ignored; bring them into use with a pulse
    for (int idx = 11; idx < 16; idx++) step(0, 0, 1, 1, idx, 3, 0);
    step(0, 0, 1, 0, 0, 0, 1);
    for (int x = 0; x < 1024; x += 7) step(1, x, 1, 0, 0, 0, 0);
    drain();

    // R9: restore a monotonic curve
    for (int k = 0; k < 11; k++) step(0, 0, 1, 1, k, k * 25, 0);
    step(0, 0, 1, 0, 0, 0, 1);

    // R4 R5: back-pressure with pseudo-random ready and valid
    strict = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      step(lfsr[0], (lfsr >> 3) & 10'h3ff, lfsr[4] | lfsr[5], 0, 0, 0, 0);
    end
    strict = 1'b1;
    drain();

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", cyc, -1);
      finish_run();
    end
  end
endmodule